// File: doc/BRIEF.md
# Dual-Accumulator Arithmetic Unit with Condition Flags

This block is the arithmetic core of a small 8-bit datapath. It holds two accumulators and a four-flag condition register: negative, zero, signed overflow and carry/borrow. Each cycle in which the strobe is high, it executes one operation on the selected accumulator and an operand from the input port.

The operations are load, store, add, subtract, compare and test. The flag rules depend on the operation class. Add and subtract write their result back to the accumulator and set all four flags. Compare and test set the flags only and never write back. Load and store set negative and zero from the data value, clear overflow and keep the carry flag as it was. Store copies the selected accumulator onto a held store-data output. Add and subtract give flags that are correct for both the signed and the unsigned reading of the same bits.

Top module: `acc_alu_cc`

## Requirements
- R1: After every load, store, add, subtract, compare or test, the N flag equals bit 7 of that operation's 8-bit result or data value.
- R2: After those same operations, Z is 1 exactly when the 8-bit result or data value is zero.
- R3: Add (op=2) writes X+M modulo 256 into the selected accumulator. C is the carry out of bit 7. V is 1 when the signed sum lies outside -128..127.
- R4: Subtract (op=3) writes X-M modulo 256 into the selected accumulator. C is 1 when M, read unsigned, exceeds X. V is 1 when the signed difference lies outside -128..127.
- R5: Compare (op=4) sets N, Z, V and C exactly as subtract does, and leaves both accumulators unchanged.
- R6: Test (op=5) ignores the operand and sets the flags from X-0, which gives N and Z from X with V=0 and C=0. Both accumulators are left unchanged.
- R7: Load (op=0) writes the operand into the selected accumulator. It takes N and Z from the operand, clears V and leaves C unchanged.
- R8: Store (op=1) drives the selected accumulator onto st_data, where it is held until the next store. It takes N and Z from that value, clears V, leaves C unchanged and leaves the accumulator unchanged.
- R9: A cycle with valid low, or with op 6 or 7, changes no accumulator, no flag and no st_data.
- R10: While rst_n is low at a rising edge, A, B, all four flags and st_data are cleared to 0. The register select is sel=0 for A and sel=1 for B. All updates take effect on the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| valid | input | 1 | Execute the operation presented this cycle |
| op | input | 3 | Operation: 0 load, 1 store, 2 add, 3 subtract, 4 compare, 5 test, 6/7 no operation |
| sel | input | 1 | Accumulator select: 0 = A, 1 = B |
| operand | input | 8 | Operand M |
| st_data | output | 8 | Value of the last stored accumulator |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry (add) or borrow (subtract) flag |

## Verification
The assertions assume that valid, op, sel and operand are stable around each rising edge. They also assume that sel only takes the values 0 and 1, and that reset stays low for at least one edge before operation begins. The stimulus meets these assumptions by changing every input only on the falling edge and by holding reset low for several cycles at the start. Every flag-setting operation can be checked against the flag rules in any cycle. Because of this, the stimulus is free to mix directed boundary operands with a long pseudo-random stream of operations and values on both accumulators.

// File: rtl/acc_alu_pkg.sv
// Package: shared operation codes and the condition-flag record for the
// accumulator arithmetic unit. Assumes a 3-bit operation field.
package acc_alu_pkg;
    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_ADD   = 3'd2,
        OP_SUB   = 3'd3,
        OP_CMP   = 3'd4,
        OP_TEST  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;
endpackage

// File: rtl/acc_regfile.sv
// Accumulator bank: NREG registers of DW bits, one write port and one read
// port. Assumes rsel and wsel stay below NREG. Also exposes all registers
// flattened, so that the checker can see them.
module acc_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 2,
    parameter int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [SELW-1:0]      wsel,
    input  logic [DW-1:0]        wdata,
    input  logic [SELW-1:0]      rsel,
    output logic [DW-1:0]        rdata,
    output logic [NREG*DW-1:0]   regs_o
);
    logic [DW-1:0] acc_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_acc
        // Hold one accumulator; load it when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc_q[i] <= '0;
            else if (we && (wsel == SELW'(i)))
                acc_q[i] <= wdata;
        end
        assign regs_o[i*DW +: DW] = acc_q[i];
    end

    // Read the selected accumulator.
    always_comb begin
        rdata = acc_q[rsel];
    end
endmodule

// File: rtl/acc_arith.sv
// Adder/subtractor: forms X+M or X-M. Returns the DW-bit result, the
// carry/borrow flag (borrow is active high) and the signed overflow flag.
// Purely combinational.
module acc_arith #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] m,
    input  logic          sub,
    output logic [DW-1:0] res,
    output logic          cflag,
    output logic          vflag
);
    logic [DW:0] sum;
    logic        x7, m7, r7;

    // One adder for both; subtraction adds the inverted operand plus one.
    always_comb begin
        sum = {1'b0, x} + {1'b0, (sub ? ~m : m)} + {{DW{1'b0}}, sub};
        res = sum[DW-1:0];
    end

    // Flag terms from the sign bits of the inputs and the result.
    always_comb begin
        x7 = x[DW-1];
        m7 = m[DW-1];
        r7 = sum[DW-1];
        if (sub) begin
            cflag = ~sum[DW];
            vflag = (x7 & ~m7 & ~r7) | (~x7 & m7 & r7);
        end else begin
            cflag = sum[DW];
            vflag = (x7 & m7 & ~r7) | (~x7 & ~m7 & r7);
        end
    end
endmodule

// File: rtl/acc_ctrl.sv
// Operation decoder: chooses the arithmetic mode and operand, the register
// write-back, the store capture and the next flag values for each operation
// class. Combinational. Assumes that ccr_q is the current flag register.
module acc_ctrl
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          valid,
    input  logic [2:0]    op,
    input  logic [DW-1:0] operand,
    input  logic [DW-1:0] rd_data,
    input  ccr_t          ccr_q,
    input  logic [DW-1:0] ar_res,
    input  logic          ar_c,
    input  logic          ar_v,
    output logic          ar_sub,
    output logic [DW-1:0] ar_m,
    output logic          reg_we,
    output logic [DW-1:0] reg_wdata,
    output logic          st_we,
    output logic          flag_we,
    output ccr_t          flag_next
);
    alu_op_e opc;

    // Arithmetic set-up depends only on the opcode.
    always_comb begin
        opc    = alu_op_e'(op);
        ar_sub = (opc == OP_SUB) || (opc == OP_CMP) || (opc == OP_TEST);
        ar_m   = (opc == OP_TEST) ? '0 : operand;
    end

    // Per-class write-back and flag rules.
    always_comb begin
        reg_we    = 1'b0;
        reg_wdata = operand;
        st_we     = 1'b0;
        flag_we   = 1'b0;
        flag_next = ccr_q;
        if (valid) begin
            case (opc)
                OP_LOAD: begin
                    reg_we      = 1'b1;
                    flag_we     = 1'b1;
                    flag_next.n = operand[DW-1];
                    flag_next.z = (operand == '0);
                    flag_next.v = 1'b0;
                end
                OP_STORE: begin
                    st_we       = 1'b1;
                    flag_we     = 1'b1;
                    flag_next.n = rd_data[DW-1];
                    flag_next.z = (rd_data == '0);
                    flag_next.v = 1'b0;
                end
                OP_ADD, OP_SUB, OP_CMP, OP_TEST: begin
                    reg_we      = (opc == OP_ADD) || (opc == OP_SUB);
                    reg_wdata   = ar_res;
                    flag_we     = 1'b1;
                    flag_next.n = ar_res[DW-1];
                    flag_next.z = (ar_res == '0);
                    flag_next.v = ar_v;
                    flag_next.c = ar_c;
                end
                default: begin
                    flag_next = ccr_q;
                end
            endcase
        end
    end
endmodule

// File: rtl/acc_alu_cc.sv
// Top level: two accumulators, an add/subtract unit, a class-based flag
// controller, the flag register and the held store-data register. Every
// state change happens on the rising edge while valid is high. The reset
// is synchronous and active low.
module acc_alu_cc
    import acc_alu_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 2,
    parameter int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic [2:0]      op,
    input  logic [SELW-1:0] sel,
    input  logic [DW-1:0]   operand,
    output logic [DW-1:0]   st_data,
    output logic            flag_n,
    output logic            flag_z,
    output logic            flag_v,
    output logic            flag_c
);
    logic [DW-1:0]      rd_data;
    logic [NREG*DW-1:0] regs_flat;
    logic [DW-1:0]      ar_res;
    logic               ar_c;
    logic               ar_v;
    logic               ar_sub;
    logic [DW-1:0]      ar_m;
    logic               reg_we;
    logic [DW-1:0]      reg_wdata;
    logic               st_we;
    logic               flag_we;
    ccr_t               flag_next;
    ccr_t               ccr_q;

    acc_regfile #(.DW(DW), .NREG(NREG), .SELW(SELW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .wsel   (sel),
        .wdata  (reg_wdata),
        .rsel   (sel),
        .rdata  (rd_data),
        .regs_o (regs_flat)
    );

    acc_arith #(.DW(DW)) u_arith (
        .x     (rd_data),
        .m     (ar_m),
        .sub   (ar_sub),
        .res   (ar_res),
        .cflag (ar_c),
        .vflag (ar_v)
    );

    acc_ctrl #(.DW(DW)) u_ctrl (
        .valid     (valid),
        .op        (op),
        .operand   (operand),
        .rd_data   (rd_data),
        .ccr_q     (ccr_q),
        .ar_res    (ar_res),
        .ar_c      (ar_c),
        .ar_v      (ar_v),
        .ar_sub    (ar_sub),
        .ar_m      (ar_m),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .st_we     (st_we),
        .flag_we   (flag_we),
        .flag_next (flag_next)
    );

    // Condition flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ccr_q <= '0;
        else if (flag_we)
            ccr_q <= flag_next;
    end

    // Store-data holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_data <= '0;
        else if (st_we)
            st_data <= rd_data;
    end

    assign flag_n = ccr_q.n;
    assign flag_z = ccr_q.z;
    assign flag_v = ccr_q.v;
    assign flag_c = ccr_q.c;
endmodule

// File: rtl/acc_alu_cc_chk.sv
// Checker for acc_alu_cc: watches the ports, the flag register and the
// accumulators over time. It is attached to the top with bind. It assumes
// that the inputs are stable at each rising edge.
module acc_alu_cc_chk
    import acc_alu_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 2,
    parameter int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               valid,
    input logic [2:0]         op,
    input logic [SELW-1:0]    sel,
    input logic [DW-1:0]      operand,
    input logic [DW-1:0]      st_data,
    input ccr_t               ccr,
    input logic [NREG*DW-1:0] regs
);
    logic [DW-1:0] xsel;
    logic [DW:0]   wide_sum;

    // Selected accumulator and a widened sum seen from outside the datapath.
    always_comb begin
        xsel     = regs[sel*DW +: DW];
        wide_sum = {1'b0, xsel} + {1'b0, operand};
    end

    assert_add_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_ADD) |=> (ccr.c == $past(wide_sum[DW])));

    assert_cmp_keeps_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (op == OP_CMP || op == OP_TEST)) |=> $stable(regs));

    assert_test_clears_vc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_TEST) |=> (!ccr.v && !ccr.c && ccr.n == $past(xsel[DW-1])));

    // Covers R1 as well: N follows the loaded value.
    assert_load_nz_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_LOAD) |=>
            (ccr.z == ($past(operand) == '0) && ccr.n == $past(operand[DW-1])));

    assert_move_v_c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (op == OP_LOAD || op == OP_STORE)) |=>
            (!ccr.v && ccr.c == $past(ccr.c)));

    assert_store_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_STORE) |=> (st_data == $past(xsel) && $stable(regs)));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid || op == OP_RSV6 || op == OP_RSV7) |=>
            ($stable(regs) && $stable(ccr) && $stable(st_data)));

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (regs == '0 && ccr == '0 && st_data == '0));
endmodule

bind acc_alu_cc acc_alu_cc_chk #(.DW(DW), .NREG(NREG), .SELW(SELW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (valid),
    .op      (op),
    .sel     (sel),
    .operand (operand),
    .st_data (st_data),
    .ccr     (ccr_q),
    .regs    (regs_flat)
);

// File: tb/sim_acc_alu_cc.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies operations, models the expected
// outputs and queues them. The monitor pops the queue and compares.
module sim_acc_alu_cc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid = 1'b0;
    logic [2:0] op = 3'd0;
    logic       sel = 1'b0;
    logic [7:0] operand = 8'd0;
    logic [7:0] st_data;
    logic       flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_acc [2];
    logic [7:0] m_st;
    logic [3:0] m_f;   // {n,z,v,c}

    logic [11:0] exp_q [$];
    string       tag_q [$];

    acc_alu_cc u0 (
        .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .sel(sel),
        .operand(operand), .st_data(st_data), .flag_n(flag_n),
        .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: st_data/NZVC actual %h/%b expected %h/%b",
                     tag, act[11:4], act[3:0], exp[11:4], exp[3:0]);
        end
    endtask

    // Apply one operation, update the model and queue the expected outputs.
    task automatic issue(input bit vld, input logic [2:0] o, input bit s,
                         input logic [7:0] d, input string tag);
        logic [7:0] x, r;
        int sx, sd, sr, ur;
        @(negedge clk);
        valid = vld; op = o; sel = s; operand = d;
        x = m_acc[s];
        if (vld) begin
            case (o)
                3'd0: begin m_acc[s] = d; m_f = {d[7], d == 8'd0, 1'b0, m_f[0]}; end
                3'd1: begin m_st = x; m_f = {x[7], x == 8'd0, 1'b0, m_f[0]}; end
                3'd2, 3'd3, 3'd4, 3'd5: begin
                    sx = $signed(x);
                    sd = (o == 3'd5) ? 0 : $signed(d);
                    if (o == 3'd2) begin
                        ur = int'(x) + int'(d);
                        sr = sx + sd;
                    end else begin
                        ur = int'(x) - ((o == 3'd5) ? 0 : int'(d));
                        sr = sx - sd;
                    end
                    r = ur[7:0];
                    m_f[3] = r[7];
                    m_f[2] = (r == 8'd0);
                    m_f[1] = (sr > 127) || (sr < -128);
                    m_f[0] = (ur > 255) || (ur < 0);
                    if (o == 3'd2 || o == 3'd3) m_acc[s] = r;
                end
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        exp_q.push_back({m_st, m_f});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare each queued expectation one half cycle after its edge.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0)
                check(tag_q.pop_front(), {st_data, flag_n, flag_z, flag_v, flag_c},
                      exp_q.pop_front());
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] lf;
        m_acc[0] = 8'd0; m_acc[1] = 8'd0; m_st = 8'd0; m_f = 4'd0;
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset", {st_data, flag_n, flag_z, flag_v, flag_c}, 12'h000);
        rst_n = 1'b1;
        issue(1, 3'd1, 0, 8'h55, "R10 store A after reset");
        issue(1, 3'd1, 1, 8'h55, "R10 store B after reset");
        // R7 load, R3 add cases
        issue(1, 3'd0, 0, 8'h20, "R7 load A");
        issue(1, 3'd2, 0, 8'h81, "R3 add no carry R1");
        issue(1, 3'd1, 0, 8'h00, "R8 store sum");
        issue(1, 3'd0, 0, 8'hFF, "R7 load FF");
        issue(1, 3'd2, 0, 8'h05, "R3 add carry");
        issue(1, 3'd0, 1, 8'h00, "R7 load zero keeps C R2");
        issue(1, 3'd1, 0, 8'h00, "R8 store wrapped sum");
        issue(1, 3'd0, 0, 8'h7F, "R7 load 7F");
        issue(1, 3'd2, 0, 8'h01, "R3 add signed overflow");
        issue(1, 3'd0, 0, 8'h80, "R7 load 80");
        issue(1, 3'd2, 0, 8'h80, "R3 add zero carry and overflow R2");
        // R4 subtract cases
        issue(1, 3'd0, 1, 8'h05, "R7 load B");
        issue(1, 3'd3, 1, 8'hFF, "R4 sub borrow");
        issue(1, 3'd1, 1, 8'h00, "R8 store difference");
        issue(1, 3'd0, 1, 8'h80, "R7 load B 80");
        issue(1, 3'd3, 1, 8'h01, "R4 sub signed overflow");
        issue(1, 3'd3, 1, 8'h7F, "R4 sub to zero R2");
        // R5 compare, R6 test
        issue(1, 3'd0, 0, 8'h10, "R7 load A 10");
        issue(1, 3'd4, 0, 8'h20, "R5 compare less");
        issue(1, 3'd4, 0, 8'h10, "R5 compare equal");
        issue(1, 3'd1, 0, 8'h00, "R5 store shows A unchanged");
        issue(1, 3'd0, 1, 8'hC3, "R7 load B C3");
        issue(1, 3'd2, 1, 8'hC3, "R3 add sets C before test");
        issue(1, 3'd5, 1, 8'hAA, "R6 test clears V and C");
        issue(1, 3'd1, 1, 8'h00, "R6 store shows B unchanged");
        // R9 idle and reserved opcodes
        issue(1, 3'd0, 0, 8'hF0, "R7 load A F0");
        issue(1, 3'd2, 0, 8'h20, "R3 add carry before idle");
        issue(0, 3'd2, 0, 8'h33, "R9 valid low add ignored");
        issue(1, 3'd6, 0, 8'h00, "R9 opcode 6 ignored");
        issue(1, 3'd7, 1, 8'hFF, "R9 opcode 7 ignored");
        issue(0, 3'd0, 1, 8'h99, "R9 valid low load ignored");
        issue(1, 3'd1, 0, 8'h00, "R9 store A after idle");
        issue(1, 3'd1, 1, 8'h00, "R9 store B after idle");
        // Mixed pseudo-random stream
        lf = 8'hA7;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            issue(1'b1, 3'(i % 6), lf[0], lf ^ 8'(i * 37), "R1 R2 R3 R4 random mix");
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule